// File: doc/BRIEF.md
# Unlock-Protected Clock Gating Controller

This block switches the clocks of seven peripheral domains on and off and holds each domain in reset under software control. Software reaches it through a zero-wait-state APB slave port with three 32-bit registers: a write-protect key register, a clock-run register and a domain-reset register. Bit position i of every register belongs to domain i.

Changing a domain's clock or reset needs two steps. Software first opens the key bit for that domain, then writes the run or reset bit. A write to the run or reset register changes only the bit positions whose key bit is 1, so a stray write cannot stop or reset a domain that is still locked. Each domain's clock passes through a glitch-free gate cell whose enable is captured while the source clock is low. The gated output therefore starts and stops only in whole high phases.

To bring up a domain, software opens its key bit and sets its reset bit. It then runs the clock for a short time so the reset takes effect, stops the clock, clears the reset, starts the clock again and closes the key bit. To shut a domain down, software opens the key bit, clears the run bit and closes the key bit.

Top module: `clkgate_ctrl`

## Requirements
- R1: After system reset the key register reads 0x00, the run register reads 0x7F (all domains clocked) and the reset register reads 0x00.
- R2: The key register is at byte offset 0x0, the run register at 0x4 and the reset register at 0x8. All three read back their value in bits 6:0, and bits 31:7 always read 0.
- R3: A write to the key register (offset 0x0) always takes bits 6:0 of the write data, whatever the key register held before.
- R4: A write to the run or reset register changes bit i only when key bit i is 1. Bits whose key bit is 0 keep their old value, even when other bits of the same write change.
- R5: dom_clk_o[i] copies pclk while run bit i is 1 and stays low while it is 0. A change to the run bit written on access edge E first shows in the high phase that follows edge E+1.
- R6: dom_rst_o[i] (active high) equals reset bit i. It changes on the access edge of the write that sets or clears the bit.
- R7: pready always reads 1 and pslverr always reads 0.
- R8: A register changes only on a clock edge where psel, penable and pwrite are all 1. A setup phase alone, or a read access, leaves all registers unchanged.
- R9: During the power-up sequence, with the key bit open, reset set and run set, the domain receives clock pulses while dom_rst_o for that domain is high.
- R10: Offset 0xC reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Source clock and APB clock |
| presetn | input | 1 | Active-low system reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address; bits 3:2 select the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| dom_clk_o | output | 7 | Gated clock for each domain |
| dom_rst_o | output | 7 | Active-high reset for each domain |

## Verification
A key register with a wrong value shows up on the first masked write after it. Bits that should have kept their value change, or bits that should have changed do not, and a read or dom_rst_o shows this on the access edge. A fault in the run register or in a gate cell shows on dom_clk_o in the high phase after the next clock edge: the clock runs when it should be low, or stays low when it should run. The bench checks this one cycle after each write. A decode fault in the address or in the access-phase qualifier shows in the next readback of whichever register it disturbed.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
   // Register select taken from byte address bits 3:2
   typedef enum logic [1:0] {
      SEL_KEY   = 2'd0,
      SEL_RUN   = 2'd1,
      SEL_RESET = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // Gate cell variants
   localparam int GATE_LATCH   = 0;
   localparam int GATE_NEGFLOP = 1;

   function automatic reg_sel_e decode_sel(input logic [1:0] word_idx);
      reg_sel_e s;
      case (word_idx)
         2'd0:    s = SEL_KEY;
         2'd1:    s = SEL_RUN;
         2'd2:    s = SEL_RESET;
         default: s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/cg_regfile.sv
module cg_regfile #(
   parameter int NDOM   = 7,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic [NDOM-1:0]   key_q,
   output logic [NDOM-1:0]   run_q,
   output logic [NDOM-1:0]   rstreg_q
);
   import clkgate_pkg::*;

   localparam logic [NDOM-1:0] RUN_INIT = {NDOM{1'b1}};
   localparam int              PAD_W    = DATA_W - NDOM;

   reg_sel_e        sel;
   logic            wr_acc;
   logic [NDOM-1:0] wbits;
   logic [NDOM-1:0] run_nx;
   logic [NDOM-1:0] rst_nx;
   logic [NDOM-1:0] rd_bits;

   assign sel    = decode_sel(paddr[3:2]);
   assign wr_acc = psel & penable & pwrite;
   assign wbits  = pwdata[NDOM-1:0];

   // Per-bit merge: open key bits take the new data, locked bits hold.
   assign run_nx = (run_q    & ~key_q) | (wbits & key_q);
   assign rst_nx = (rstreg_q & ~key_q) | (wbits & key_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q    <= '0;
         run_q    <= RUN_INIT;
         rstreg_q <= '0;
      end else if (wr_acc) begin
         case (sel)
            SEL_KEY:   key_q    <= wbits;
            SEL_RUN:   run_q    <= run_nx;
            SEL_RESET: rstreg_q <= rst_nx;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_KEY:   rd_bits = key_q;
         SEL_RUN:   rd_bits = run_q;
         SEL_RESET: rd_bits = rstreg_q;
         default:   rd_bits = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign prdata = {{PAD_W{1'b0}}, rd_bits};
      end else begin : g_nopad
         assign prdata = rd_bits;
      end
   endgenerate
endmodule

// File: rtl/cg_cell.sv
module cg_cell #(
   parameter int STYLE = 0
) (
   input  logic clk,
   input  logic en,
   output logic gclk
);
   import clkgate_pkg::*;

   logic en_hold;

   generate
      if (STYLE == GATE_LATCH) begin : g_latch
         // Transparent while clk is low; frozen through the high phase
         always_latch begin
            if (!clk) en_hold = en;
         end
      end else begin : g_negflop
         always_ff @(negedge clk) en_hold <= en;
      end
   endgenerate

   assign gclk = clk & en_hold;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
   parameter int NDOM       = 7,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int GATE_STYLE = 0
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [NDOM-1:0]   dom_clk_o,
   output logic [NDOM-1:0]   dom_rst_o
);
   generate
      if (NDOM < 1 || NDOM > DATA_W) begin : g_bad_ndom
         $error("clkgate_ctrl: NDOM must be between 1 and DATA_W");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("clkgate_ctrl: ADDR_W must be at least 4");
      end
      if (GATE_STYLE != 0 && GATE_STYLE != 1) begin : g_bad_style
         $error("clkgate_ctrl: GATE_STYLE must be 0 or 1");
      end
   endgenerate

   logic [NDOM-1:0] key_q;
   logic [NDOM-1:0] run_q;
   logic [NDOM-1:0] rstreg_q;

   cg_regfile #(
      .NDOM  (NDOM),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk     (pclk),
      .rst_n   (presetn),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .prdata  (prdata),
      .key_q   (key_q),
      .run_q   (run_q),
      .rstreg_q(rstreg_q)
   );

   assign pready    = 1'b1;
   assign pslverr   = 1'b0;
   assign dom_rst_o = rstreg_q;

   generate
      for (genvar i = 0; i < NDOM; i++) begin : g_dom
         cg_cell #(.STYLE(GATE_STYLE)) u_gate (
            .clk (pclk),
            .en  (run_q[i]),
            .gclk(dom_clk_o[i])
         );
      end
   endgenerate
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
   parameter int NDOM   = 7,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic [DATA_W-1:0] prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [NDOM-1:0]   dom_rst_o,
   input logic [NDOM-1:0]   key_q,
   input logic [NDOM-1:0]   run_q
);
   AST_ZERO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
      pready && !pslverr); // R7

   AST_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (prdata >> NDOM) == '0); // R2

   AST_KEY_TAKEN: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && pwrite && paddr[3:2] == 2'd0)
      |=> key_q == $past(pwdata[NDOM-1:0])); // R3

   AST_RUN_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> ((run_q & ~$past(key_q)) == ($past(run_q) & ~$past(key_q)))); // R4

   AST_RST_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> ((dom_rst_o & ~$past(key_q)) == ($past(dom_rst_o) & ~$past(key_q)))); // R4

   AST_NO_ACCESS_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
      !(psel && penable && pwrite)
      |=> ($stable(key_q) && $stable(run_q) && $stable(dom_rst_o))); // R8
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
   .NDOM  (NDOM),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .pclk     (pclk),
   .presetn  (presetn),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .prdata   (prdata),
   .pready   (pready),
   .pslverr  (pslverr),
   .dom_rst_o(dom_rst_o),
   .key_q    (key_q),
   .run_q    (run_q)
);

// File: tb/clkgate_ctrl_test.sv
`timescale 1ns/1ps
module clkgate_ctrl_test;
   localparam int ND = 7;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [3:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [ND-1:0] dom_clk_o;
   logic [ND-1:0] dom_rst_o;

   int n_vec = 0;
   int n_bad = 0;
   logic [ND-1:0] m_key, m_run, m_rst;
   int pulses_in_reset = 0;

   always #4 pclk = ~pclk;   // 125 MHz

   clkgate_ctrl uut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .dom_clk_o(dom_clk_o),
      .dom_rst_o(dom_rst_o)
   );

   always @(posedge dom_clk_o[3]) if (dom_rst_o[3]) pulses_in_reset++;

   function automatic logic [ND-1:0] merge(input logic [ND-1:0] old,
                                           input logic [ND-1:0] nw,
                                           input logic [ND-1:0] key);
      return (old & ~key) | (nw & key);
   endfunction

   function automatic logic [31:0] model_read(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {25'd0, m_key};
         2'd1:    return {25'd0, m_run};
         2'd2:    return {25'd0, m_rst};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1;
      @(posedge pclk);
      case (a[3:2])
         2'd0: m_key = d[ND-1:0];
         2'd1: m_run = merge(m_run, d[ND-1:0], m_key);
         2'd2: m_rst = merge(m_rst, d[ND-1:0], m_key);
         default: ;
      endcase
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
      #1 check("R6 reset outputs", {25'd0, dom_rst_o}, {25'd0, m_rst});
   endtask

   task automatic apb_read_check(input logic [3:0] a, input string req);
      @(negedge pclk);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge pclk);
      penable = 1;
      #1 check(req, prdata, model_read(a));
      check("R7 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      @(negedge pclk);
      psel = 0; penable = 0;
   endtask

   task automatic clock_check(input string req);
      @(posedge pclk); #2;
      check(req, {25'd0, dom_clk_o}, {25'd0, m_run});
      @(negedge pclk); #1;
      check({req, " low phase"}, {25'd0, dom_clk_o}, 32'd0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      m_key = '0; m_run = '1; m_rst = '0;
      repeat (3) @(posedge pclk);
      #1 presetn = 1;

      // R1 reset values
      apb_read_check(4'h0, "R1 key reset");
      apb_read_check(4'h4, "R1 run reset");
      apb_read_check(4'h8, "R1 reset-reg reset");
      clock_check("R5 all clocks after reset");

      // R4 locked writes ignored
      apb_write(4'h4, 32'h0);
      apb_read_check(4'h4, "R4 locked run write");
      clock_check("R4 clocks unchanged");

      // R3 + R4 partial key
      apb_write(4'h0, 32'hFFFF_FF05);
      apb_read_check(4'h0, "R3 key write");
      apb_write(4'h4, 32'h0000_0000);
      apb_read_check(4'h4, "R4 partial run write");
      clock_check("R5 partial gating");
      apb_write(4'h8, 32'hFFFF_FFFF);
      apb_read_check(4'h8, "R4 partial reset write");

      // R10 unused offset
      apb_write(4'hC, 32'hFFFF_FFFF);
      apb_read_check(4'hC, "R10 unused offset");
      apb_read_check(4'h0, "R10 key after unused write");
      apb_read_check(4'h4, "R10 run after unused write");

      // R8 setup phase only
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0; paddr = 4'h0; pwdata = 32'h7F;
      repeat (3) @(negedge pclk);
      psel = 0; pwrite = 0;
      apb_read_check(4'h0, "R8 setup-only write ignored");

      // R9 power-up sequence on domain 3, starting locked and off
      apb_write(4'h0, 32'h08);
      apb_write(4'h8, 32'h00);
      apb_write(4'h4, 32'h00);
      apb_write(4'h8, 32'h08);
      pulses_in_reset = 0;
      apb_write(4'h4, 32'h08);
      repeat (4) @(posedge pclk);
      apb_write(4'h4, 32'h00);
      check("R9 pulses under reset", {31'd0, pulses_in_reset > 0}, 32'd1);
      apb_write(4'h8, 32'h00);
      apb_write(4'h4, 32'h08);
      apb_write(4'h0, 32'h00);
      clock_check("R9 domain running after power-up");
      apb_read_check(4'h8, "R9 reset released");

      // Power-down domain 3
      apb_write(4'h0, 32'h08);
      apb_write(4'h4, 32'h00);
      apb_write(4'h0, 32'h00);
      clock_check("R5 domain stopped after power-down");

      // Constrained random mix
      for (int k = 0; k < 400; k++) begin
         logic [3:0]  a;
         logic [31:0] d;
         a = {2'($urandom_range(0, 3)), 2'b00};
         d = $urandom;
         if ($urandom_range(0, 3) != 0) begin
            apb_write(a, d);
            if (a[3:2] == 2'd1) clock_check("R5 random gating");
         end
         apb_read_check({2'($urandom_range(0, 3)), 2'b00}, "R2 R4 random readback");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule